// File: doc/BRIEF.md
# Clock Source Control Register Block

This block is the register front end for three clock sources: an internal oscillator, an external oscillator and a PLL. Through a simple write/read port, software switches each source on or off, configures the PLL and picks which source drives the system clock. The PLL settings are its reference source, an input divider M, a multiplier N and an output divider selected by a 2-bit field P. The block drives the enable lines and the decoded ratios that the clock generation logic uses. It does not model oscillators, the analog PLL or lock timing.

Some writes are legal to perform but unsafe: turning off a source that currently feeds the system clock, reconfiguring a running PLL, loading an out-of-range M/N pair, or selecting a source code that does not exist. The block records each of these in its own sticky error flag. Software clears a flag by writing a one to it. The enable register has no stored copy of the written word. A read of it returns the live enable state.

Top module: `clkctl_top`

## Requirements
- R1: After a synchronous reset, the block is in this state. The internal oscillator is on. The external oscillator and the PLL are off. The system clock select is 0. All error flags are clear. The PLL settings are M=16, N=192, P=0 and source internal. So the enable register reads 0x1, the PLL register reads 0x0000C010, and the select and status registers read 0.
- R2: A write to address 0 sets the enables from the written data: bit 0 is the internal oscillator, bit 1 the external oscillator and bit 2 the PLL. A read of address 0 returns those three live enables in the same bit positions, with all other bits zero.
- R3: Writing the PLL enable to 0 while the PLL is on and the select is 2 (PLL) still turns the PLL off. It also sets status bit 0.
- R4: Writing the external oscillator enable to 0 while that oscillator is on sets status bit 1 in either of two cases. The first case is a select of 1. The second case is a select of 2 with the PLL source set to external.
- R5: Writing the internal oscillator enable to 0 while that oscillator is on sets status bit 2 in either of two cases. The first case is a select of 0. The second case is a select of 2 with the PLL source set to internal.
- R6: The PLL register is at address 1, with M in bits 5:0, N in bits 16:8, P in bits 21:20 and the source in bit 24 (0 internal, 1 external). A write that changes any of these fields while the PLL is on sets status bit 3. A write made with `init_wr` high never sets this flag.
- R7: The `pll_out_div` output equals 2 + 2·P for the stored P.
- R8: A PLL write with N < 64, N > 432 or M < 2 sets status bit 4. The raw fields are still stored and read back. However, `vco_mul` and `vco_div` keep their last valid values. A valid pair updates them on the next clock.
- R9: The select register is at address 2, bits 1:0. Codes 0, 1 and 2 choose the internal oscillator, the external oscillator and the PLL. A write of code 3 leaves the select unchanged and sets status bit 5.
- R10: The status register is at address 3, and each flag stays set until it is cleared. A write there clears each flag whose data bit is one. Flags whose data bit is zero are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| init_wr | input | 1 | Marks the write as an initialisation write (skips the reconfiguration check) |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 32 | Combinational read data |
| int_osc_en | output | 1 | Internal oscillator enable |
| ext_osc_en | output | 1 | External oscillator enable |
| pll_en | output | 1 | PLL enable |
| sysclk_sel | output | 2 | System clock source code |
| pll_src | output | 1 | PLL reference source (1 = external) |
| vco_mul | output | 9 | Effective multiplier N |
| vco_div | output | 6 | Effective input divider M |
| pll_out_div | output | 4 | PLL output divide ratio |
| err_flags | output | 6 | Sticky error flags |

## Verification
The guard checks are tried in two forms. In one, the source being switched off is in use through the select alone. In the other, it is in use through the select and the PLL source together. Disables of sources that are not in use are checked to raise no flag, which separates the in-use decode from a plain detector of a 1-to-0 change. Reconfiguration writes are sent with and without the initialisation marker, and flags are cleared one bit at a time, which shows that the flags are independent and sticky. The M/N patterns sit on both sides of each range limit: 63/64 and 432/433 for N, and 1/2 for M. These show that the limits are inclusive and that a rejected pair is still visible on read-back but has no effect on the ratio outputs.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int M_W      = 6;
    localparam int N_W      = 9;
    localparam int P_W      = 2;
    localparam int ODIV_W   = P_W + 2;
    localparam int ERR_N    = 6;

    localparam logic [ADDR_W-1:0] A_ENABLE = 2'd0;
    localparam logic [ADDR_W-1:0] A_PLLCFG = 2'd1;
    localparam logic [ADDR_W-1:0] A_SELECT = 2'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;

    localparam int EN_INT = 0;
    localparam int EN_EXT = 1;
    localparam int EN_PLL = 2;

    localparam int F_M_LO = 0;
    localparam int F_N_LO = 8;
    localparam int F_P_LO = 20;
    localparam int F_SRC  = 24;

    localparam int E_PLL_OFF = 0;
    localparam int E_EXT_OFF = 1;
    localparam int E_INT_OFF = 2;
    localparam int E_RECFG   = 3;
    localparam int E_BAD_MN  = 4;
    localparam int E_BAD_SEL = 5;

    typedef enum logic [1:0] {
        SRC_INT = 2'd0,
        SRC_EXT = 2'd1,
        SRC_PLL = 2'd2,
        SRC_BAD = 2'd3
    } sysclk_e;

    typedef struct packed {
        logic           src;
        logic [P_W-1:0] p;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } pll_cfg_t;

    localparam pll_cfg_t CFG_RESET = '{src: 1'b0, p: '0, n: N_W'(192), m: M_W'(16)};

    function automatic pll_cfg_t cfg_unpack(input logic [DATA_W-1:0] d);
        pll_cfg_t c;
        c.m   = d[F_M_LO +: M_W];
        c.n   = d[F_N_LO +: N_W];
        c.p   = d[F_P_LO +: P_W];
        c.src = d[F_SRC];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_pack(input pll_cfg_t c);
        logic [DATA_W-1:0] d;
        d = '0;
        d[F_M_LO +: M_W] = c.m;
        d[F_N_LO +: N_W] = c.n;
        d[F_P_LO +: P_W] = c.p;
        d[F_SRC]         = c.src;
        return d;
    endfunction

    function automatic logic [ODIV_W-1:0] out_ratio(input logic [P_W-1:0] p);
        return ODIV_W'(2) + (ODIV_W'(p) << 1);
    endfunction

endpackage

// File: rtl/clkctl_mn_check.sv
module clkctl_mn_check
    import clkctl_pkg::*;
#(
    parameter int N_MIN = 64,
    parameter int N_MAX = 432,
    parameter int M_MIN = 2
) (
    input  pll_cfg_t cfg,
    output logic     ok
);
    always_comb begin
        ok = (int'(cfg.n) >= N_MIN) && (int'(cfg.n) <= N_MAX) && (int'(cfg.m) >= M_MIN);
    end
endmodule

// File: rtl/clkctl_guard.sv
module clkctl_guard
    import clkctl_pkg::*;
(
    input  logic                wr_en,
    input  logic                init_wr,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                int_on,
    input  logic                ext_on,
    input  logic                pll_on,
    input  sysclk_e             sel,
    input  pll_cfg_t            cur_cfg,
    input  logic                new_mn_ok,
    output logic [ERR_N-1:0]    events
);
    logic     w_en, w_cfg, w_sel;
    pll_cfg_t new_cfg;
    logic     pll_feeds_from_ext, pll_feeds_from_int;

    always_comb begin
        w_en    = wr_en && (wr_addr == A_ENABLE);
        w_cfg   = wr_en && (wr_addr == A_PLLCFG);
        w_sel   = wr_en && (wr_addr == A_SELECT);
        new_cfg = cfg_unpack(wr_data);

        pll_feeds_from_ext = (sel == SRC_PLL) && cur_cfg.src;
        pll_feeds_from_int = (sel == SRC_PLL) && !cur_cfg.src;

        events = '0;
        events[E_PLL_OFF] = w_en && pll_on && !wr_data[EN_PLL] && (sel == SRC_PLL);
        events[E_EXT_OFF] = w_en && ext_on && !wr_data[EN_EXT] &&
                            ((sel == SRC_EXT) || pll_feeds_from_ext);
        events[E_INT_OFF] = w_en && int_on && !wr_data[EN_INT] &&
                            ((sel == SRC_INT) || pll_feeds_from_int);
        events[E_RECFG]   = w_cfg && !init_wr && pll_on && (new_cfg != cur_cfg);
        events[E_BAD_MN]  = w_cfg && !new_mn_ok;
        events[E_BAD_SEL] = w_sel && (wr_data[1:0] == 2'd3);
    end
endmodule

// File: rtl/clkctl_sticky.sv
module clkctl_sticky #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] flags
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (set_vec[i])
                flags[i] <= 1'b1;
            else if (clr_vec[i])
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
    import clkctl_pkg::*;
#(
    parameter int N_MIN = 64,
    parameter int N_MAX = 432,
    parameter int M_MIN = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                init_wr,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                int_osc_en,
    output logic                ext_osc_en,
    output logic                pll_en,
    output logic [1:0]          sysclk_sel,
    output logic                pll_src,
    output logic [N_W-1:0]      vco_mul,
    output logic [M_W-1:0]      vco_div,
    output logic [ODIV_W-1:0]   pll_out_div,
    output logic [ERR_N-1:0]    err_flags
);
    logic               int_q, ext_q, pll_q;
    sysclk_e            sel_q;
    pll_cfg_t           cfg_q;
    logic [N_W-1:0]     eff_n_q;
    logic [M_W-1:0]     eff_m_q;
    pll_cfg_t           wr_cfg;
    logic               wr_mn_ok;
    logic [ERR_N-1:0]   ev;
    logic [ERR_N-1:0]   clr;

    assign wr_cfg = cfg_unpack(wr_data);

    clkctl_mn_check #(.N_MIN(N_MIN), .N_MAX(N_MAX), .M_MIN(M_MIN)) u_mn (
        .cfg (wr_cfg),
        .ok  (wr_mn_ok)
    );

    clkctl_guard u_guard (
        .wr_en     (wr_en),
        .init_wr   (init_wr),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .int_on    (int_q),
        .ext_on    (ext_q),
        .pll_on    (pll_q),
        .sel       (sel_q),
        .cur_cfg   (cfg_q),
        .new_mn_ok (wr_mn_ok),
        .events    (ev)
    );

    assign clr = (wr_en && (wr_addr == A_STATUS)) ? wr_data[ERR_N-1:0] : '0;

    clkctl_sticky #(.WIDTH(ERR_N)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (ev),
        .clr_vec (clr),
        .flags   (err_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            int_q   <= 1'b1;
            ext_q   <= 1'b0;
            pll_q   <= 1'b0;
            sel_q   <= SRC_INT;
            cfg_q   <= CFG_RESET;
            eff_n_q <= CFG_RESET.n;
            eff_m_q <= CFG_RESET.m;
        end else if (wr_en) begin
            case (wr_addr)
                A_ENABLE: begin
                    int_q <= wr_data[EN_INT];
                    ext_q <= wr_data[EN_EXT];
                    pll_q <= wr_data[EN_PLL];
                end
                A_PLLCFG: begin
                    cfg_q <= wr_cfg;
                    if (wr_mn_ok) begin
                        eff_n_q <= wr_cfg.n;
                        eff_m_q <= wr_cfg.m;
                    end
                end
                A_SELECT: begin
                    if (wr_data[1:0] != 2'd3)
                        sel_q <= sysclk_e'(wr_data[1:0]);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_ENABLE: begin
                rd_data[EN_INT] = int_q;
                rd_data[EN_EXT] = ext_q;
                rd_data[EN_PLL] = pll_q;
            end
            A_PLLCFG: rd_data = cfg_pack(cfg_q);
            A_SELECT: rd_data[1:0] = sel_q;
            default:  rd_data[ERR_N-1:0] = err_flags;
        endcase
    end

    assign int_osc_en  = int_q;
    assign ext_osc_en  = ext_q;
    assign pll_en      = pll_q;
    assign sysclk_sel  = sel_q;
    assign pll_src     = cfg_q.src;
    assign vco_mul     = eff_n_q;
    assign vco_div     = eff_m_q;
    assign pll_out_div = out_ratio(cfg_q.p);

endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk
    import clkctl_pkg::*;
#(
    parameter int N_MIN = 64,
    parameter int N_MAX = 432,
    parameter int M_MIN = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic                pll_en,
    input logic [1:0]          sysclk_sel,
    input logic [N_W-1:0]      vco_mul,
    input logic [M_W-1:0]      vco_div,
    input logic [ERR_N-1:0]    err_flags
);
    logic wr_bad_mn;
    assign wr_bad_mn = wr_en && (wr_addr == A_PLLCFG) &&
        ((int'(wr_data[F_N_LO +: N_W]) < N_MIN) || (int'(wr_data[F_N_LO +: N_W]) > N_MAX) ||
         (int'(wr_data[F_M_LO +: M_W]) < M_MIN));

    p_pll_off_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_ENABLE && !wr_data[EN_PLL] && pll_en && sysclk_sel == 2'd2)
        |=> (err_flags[E_PLL_OFF] && !pll_en));

    p_ratio_legal_r8: assert property (@(posedge clk) disable iff (rst)
        (int'(vco_mul) >= N_MIN) && (int'(vco_mul) <= N_MAX) && (int'(vco_div) >= M_MIN));

    p_bad_mn_hold_r8: assert property (@(posedge clk) disable iff (rst)
        wr_bad_mn |=> ($stable(vco_mul) && $stable(vco_div) && err_flags[E_BAD_MN]));

    p_sel_reject_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_SELECT && wr_data[1:0] == 2'd3)
        |=> ($stable(sysclk_sel) && err_flags[E_BAD_SEL]));

    p_sel_legal_r9: assert property (@(posedge clk) disable iff (rst)
        sysclk_sel != 2'd3);

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == A_STATUS)
        |=> ((err_flags & $past(err_flags)) == $past(err_flags)));
endmodule

bind clkctl_top clkctl_chk #(.N_MIN(N_MIN), .N_MAX(N_MAX), .M_MIN(M_MIN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pll_en     (pll_en),
    .sysclk_sel (sysclk_sel),
    .vco_mul    (vco_mul),
    .vco_div    (vco_div),
    .err_flags  (err_flags)
);

// File: tb/sim_clkctl_top.sv
module sim_clkctl_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, init_wr;
    logic [1:0]  wr_addr, rd_addr;
    logic [31:0] wr_data, rd_data;
    logic        int_osc_en, ext_osc_en, pll_en, pll_src;
    logic [1:0]  sysclk_sel;
    logic [8:0]  vco_mul;
    logic [5:0]  vco_div;
    logic [3:0]  pll_out_div;
    logic [5:0]  err_flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    clkctl_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .init_wr(init_wr),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .int_osc_en(int_osc_en), .ext_osc_en(ext_osc_en), .pll_en(pll_en),
        .sysclk_sel(sysclk_sel), .pll_src(pll_src), .vco_mul(vco_mul),
        .vco_div(vco_div), .pll_out_div(pll_out_div), .err_flags(err_flags)
    );

    // {write addr, init, write data, read addr, expected read}
    localparam int NV = 22;
    localparam logic [68:0] VEC [NV] = '{
        {2'd0, 1'b0, 32'h0000_0007, 2'd0, 32'h0000_0007},  // R2 all on
        {2'd2, 1'b0, 32'h0000_0002, 2'd2, 32'h0000_0002},  // R9 select PLL
        {2'd0, 1'b0, 32'h0000_0003, 2'd3, 32'h0000_0001},  // R3 PLL off in use
        {2'd3, 1'b0, 32'h0000_0001, 2'd3, 32'h0000_0000},  // R10 clear
        {2'd1, 1'b0, 32'h0110_6408, 2'd1, 32'h0110_6408},  // R6 PLL off: no flag
        {2'd0, 1'b0, 32'h0000_0007, 2'd0, 32'h0000_0007},  // R2 PLL on
        {2'd0, 1'b0, 32'h0000_0005, 2'd3, 32'h0000_0002},  // R4 ext via PLL src
        {2'd0, 1'b0, 32'h0000_0007, 2'd3, 32'h0000_0002},  // R10 sticky
        {2'd1, 1'b0, 32'h0120_6408, 2'd3, 32'h0000_000A},  // R6 reconfig flagged
        {2'd1, 1'b1, 32'h0130_6408, 2'd3, 32'h0000_000A},  // R6 init write skipped
        {2'd3, 1'b0, 32'h0000_0008, 2'd3, 32'h0000_0002},  // R10 single-bit clear
        {2'd3, 1'b0, 32'h0000_0002, 2'd3, 32'h0000_0000},  // R10
        {2'd2, 1'b0, 32'h0000_0000, 2'd2, 32'h0000_0000},  // R9 select internal
        {2'd0, 1'b0, 32'h0000_0006, 2'd3, 32'h0000_0004},  // R5 internal off in use
        {2'd2, 1'b0, 32'h0000_0003, 2'd2, 32'h0000_0000},  // R9 code 3 rejected
        {2'd3, 1'b0, 32'h0000_0000, 2'd3, 32'h0000_0024},  // R10 zero clears nothing
        {2'd3, 1'b0, 32'h0000_003F, 2'd3, 32'h0000_0000},  // R10 clear all
        {2'd0, 1'b0, 32'h0000_0003, 2'd3, 32'h0000_0000},  // R3 PLL off not in use
        {2'd1, 1'b0, 32'h0001_F408, 2'd1, 32'h0001_F408},  // R8 N=500 stored
        {2'd3, 1'b0, 32'h0000_0000, 2'd3, 32'h0000_0010},  // R8 flag
        {2'd1, 1'b0, 32'h0000_C801, 2'd1, 32'h0000_C801},  // R8 M=1 stored
        {2'd3, 1'b0, 32'h0000_0010, 2'd3, 32'h0000_0000}   // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [31:0] d, input logic ini);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; init_wr = ini;
        @(negedge clk);
        wr_en = 1'b0; init_wr = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; init_wr = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        read_chk("R1 enable", 2'd0, 32'h1);
        read_chk("R1 pllcfg", 2'd1, 32'h0000_C010);
        read_chk("R1 select", 2'd2, 32'h0);
        read_chk("R1 status", 2'd3, 32'h0);
        check("R1 ratios", {23'd0, vco_mul}, 32'd192);
        check("R1 div", {26'd0, vco_div}, 32'd16);
        check("R7 reset outdiv", {28'd0, pll_out_div}, 32'd2);

        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][68:67], VEC[i][65:34], VEC[i][66]);
            read_chk($sformatf("table row %0d", i), VEC[i][33:32], VEC[i][31:0]);
        end

        check("R8 mul kept", {23'd0, vco_mul}, 32'd100);
        check("R8 div kept", {26'd0, vco_div}, 32'd8);
        check("R7 P=0", {28'd0, pll_out_div}, 32'd2);
        check("R2 enables", {29'd0, pll_en, ext_osc_en, int_osc_en}, 32'h3);

        do_write(2'd1, 32'h0030_4002, 1'b0);
        check("R8 N=64 M=2 mul", {23'd0, vco_mul}, 32'd64);
        check("R8 N=64 M=2 div", {26'd0, vco_div}, 32'd2);
        check("R7 P=3", {28'd0, pll_out_div}, 32'd8);
        do_write(2'd1, 32'h0010_4002, 1'b0);
        check("R7 P=1", {28'd0, pll_out_div}, 32'd4);
        do_write(2'd1, 32'h0001_B03F, 1'b0);
        check("R8 N=432", {23'd0, vco_mul}, 32'd432);
        check("R8 M=63", {26'd0, vco_div}, 32'd63);
        check("R8 no flag", {26'd0, err_flags}, 32'h0);
        do_write(2'd1, 32'h0001_B13F, 1'b0);
        check("R8 N=433 kept", {23'd0, vco_mul}, 32'd432);
        check("R8 N=433 flag", {26'd0, err_flags}, 32'h10);
        do_write(2'd1, 32'h0000_3F02, 1'b0);
        check("R8 N=63 kept", {23'd0, vco_mul}, 32'd432);

        do_write(2'd1, 32'h0100_4002, 1'b0);
        check("R6 src port", {31'd0, pll_src}, 32'd1);
        do_write(2'd2, 32'h1, 1'b0);
        check("R9 select port", {30'd0, sysclk_sel}, 32'd1);
        do_write(2'd3, 32'h3F, 1'b0);
        do_write(2'd0, 32'h1, 1'b0);
        check("R4 ext off direct", {26'd0, err_flags}, 32'h02);
        check("R2 ext off", {31'd0, ext_osc_en}, 32'd0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule